// File: doc/BRIEF.md
# Periodic Battery Health Monitor

This block schedules load tests of a backup cell and keeps a sticky low-battery warning. Time is measured only in pulses of a system tick input, so the length of a test window and the interval between routine tests are both parameters in tick units. The defaults assume a 1 ms tick, giving a one-second load window and a 24-hour interval. A bench can scale both down to a few ticks.

Whenever the power-good input is high, the monitor first runs a test. That happens after reset and again after every return of power. It then runs a test each time the interval elapses. During a test the load-enable output is held high for the whole window. The digitized comparator flag (battery above 2.6 V) is sampled on the window's final tick, and that sample is the result. A failing result raises the warning. Only a passing test that followed a power-up lowers it again. Losing power aborts any running test, stops the interval schedule and keeps the warning as it is. The warning is presented as an enable for an external pull-down, since the pin it models may only sink current.

Top module: `batt_health_monitor`

## Requirements
- R1: While rst_n is low at a clock edge, load_en and warn_pull_low are both 0 after that edge.
- R2: With pwr_good sampled high at the first edge after reset or after a power loss, load_en is 1 after that edge, which starts a power-up test.
- R3: A test keeps load_en at 1 until WINDOW_TICKS tick pulses have been sampled. load_en is 0 after the edge that samples the last of them.
- R4: The test result is the value of batt_above_trip at the edge that samples the window's final tick. Values at earlier cycles of the window have no effect.
- R5: A test whose result is 0 sets warn_pull_low to 1 at the same edge where load_en falls.
- R6: A routine (interval) test that passes leaves warn_pull_low unchanged.
- R7: A power-up test runs even when warn_pull_low is 1. If it passes, warn_pull_low is 0 after its final edge.
- R8: After a test ends with power present, the next test starts (load_en 1) after the edge that samples the PERIOD_TICKS-th tick pulse counted from that end.
- R9: pwr_good sampled low makes load_en 0 after that edge. Any running test is aborted without changing the warning, and ticks start no test while power is absent.
- R10: warn_pull_low keeps its value across a power loss and return, until a test result changes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle time-base pulse; all timing is counted in these |
| pwr_good | input | 1 | Main power valid and recovery period complete |
| batt_above_trip | input | 1 | Comparator flag: battery above 2.6 V under load |
| load_en | output | 1 | Connects the test load to the cell |
| warn_pull_low | output | 1 | 1 = pull the active-low warning line low |

## Verification
The main sequence covers three kinds of run. The first is a clean power-up and interval cycle with the comparator low in mid-window but high on the final tick, which separates end-of-window sampling from any earlier sampling. The second is a routine test that fails and is followed by a routine test that passes, which separates the sticky warning from a plain follow-the-result flag. The third uses power losses during idle and during a test, then a passing power-up retest. These show whether an abort leaves a partial window count and whether only power-up tests may clear the warning. A last run has a failing power-up test on a clean warning, followed by a reset that clears everything.

// File: rtl/bhm_pkg.sv
// Package: shared types for the battery health monitor.
// Assumes: nothing beyond IEEE 1800-2017.
package bhm_pkg;

    // Sequencer states: unpowered, waiting for the interval, load applied.
    typedef enum logic [1:0] {
        SEQ_OFF  = 2'd0,
        SEQ_IDLE = 2'd1,
        SEQ_TEST = 2'd2
    } seq_state_t;

endpackage

// File: rtl/bhm_tick_counter.sv
// Module: bhm_tick_counter
// Counts tick pulses while run is high and raises expire combinationally
// when the LIMIT-th pulse is sampled. The count returns to zero whenever
// run is low or on expiry, so each run starts from zero.
// Assumes: LIMIT >= 1; tick is a single-cycle pulse in the clk domain.
module bhm_tick_counter #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic expire
);
    localparam int CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt;

    // Expiry: running, a tick arrives and it is the last one of the span.
    always_comb expire = run && tick && (cnt == LAST);

    // Count ticks during a run; clear when idle or on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || expire) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end

    // The count never reaches the limit itself (R3 window, R8 interval).
    assert_count_in_span_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CNT_W'(LIMIT));

    // Stopping a run leaves a zero count behind (R9 abort).
    assert_stop_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> cnt == '0);

endmodule

// File: rtl/bhm_warn_latch.sv
// Module: bhm_warn_latch
// Holds the sticky low-battery warning. A failing test sets it. A passing
// test clears it only if that test was the one run after power-up.
// Power loss does not touch it; only reset does.
// Assumes: done is a single-cycle pulse at the window's final tick.
module bhm_warn_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic done,
    input  logic result_ok,
    input  logic pwrup_test,
    output logic warn
);
    // Update the warning from each completed test.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            warn <= 1'b0;
        end else if (done && !result_ok) begin
            warn <= 1'b1;
        end else if (done && result_ok && pwrup_test) begin
            warn <= 1'b0;
        end
    end

    // A failing result always raises the warning.
    assert_fail_sets_warn_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !result_ok) |=> warn);

    // A passing routine test never lowers an active warning.
    assert_routine_pass_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result_ok && !pwrup_test && warn) |=> warn);

    // A passing power-up retest releases the warning.
    assert_pwrup_pass_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result_ok && pwrup_test) |=> !warn);

    // Without a completed test the warning holds (R10 retention).
    assert_hold_without_test_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> $stable(warn));

endmodule

// File: rtl/batt_health_monitor.sv
// Module: batt_health_monitor (top)
// Sequences battery load tests: one on every power-up, then one after every
// PERIOD_TICKS idle ticks. Each test drives load_en for WINDOW_TICKS ticks
// and takes the comparator flag on the last tick as its result.
// Assumes: pwr_good, tick and batt_above_trip are synchronous to clk;
// pwr_good already includes the supply recovery delay.
module batt_health_monitor #(
    parameter int WINDOW_TICKS = 1000,
    parameter int PERIOD_TICKS = 86_400_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic pwr_good,
    input  logic batt_above_trip,
    output logic load_en,
    output logic warn_pull_low
);
    import bhm_pkg::*;

    seq_state_t state;
    logic       pwrup_test;
    logic       win_done;
    logic       period_due;
    logic       win_run;
    logic       idle_run;

    // Counter run enables follow the sequencer state.
    always_comb begin
        win_run  = (state == SEQ_TEST) && pwr_good;
        idle_run = (state == SEQ_IDLE) && pwr_good;
    end

    // Test window timer.
    bhm_tick_counter #(.LIMIT(WINDOW_TICKS)) u_window (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (win_run),
        .tick   (tick),
        .expire (win_done)
    );

    // Interval timer between tests.
    bhm_tick_counter #(.LIMIT(PERIOD_TICKS)) u_interval (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (idle_run),
        .tick   (tick),
        .expire (period_due)
    );

    // Sticky warning.
    bhm_warn_latch u_warn (
        .clk        (clk),
        .rst_n      (rst_n),
        .done       (win_done),
        .result_ok  (batt_above_trip),
        .pwrup_test (pwrup_test),
        .warn       (warn_pull_low)
    );

    // Sequencer: power-up test, idle interval, routine test, abort on loss.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= SEQ_OFF;
            pwrup_test <= 1'b0;
        end else if (!pwr_good) begin
            state      <= SEQ_OFF;
            pwrup_test <= 1'b0;
        end else begin
            unique case (state)
                SEQ_OFF: begin
                    state      <= SEQ_TEST;
                    pwrup_test <= 1'b1;
                end
                SEQ_IDLE: begin
                    if (period_due) begin
                        state      <= SEQ_TEST;
                        pwrup_test <= 1'b0;
                    end
                end
                SEQ_TEST: begin
                    if (win_done) begin
                        state <= SEQ_IDLE;
                    end
                end
                default: begin
                    state <= SEQ_OFF;
                end
            endcase
        end
    end

    // The load is applied exactly while a test is in progress.
    always_comb load_en = (state == SEQ_TEST);

    // Power absent at an edge leaves the load off afterwards.
    assert_unpowered_load_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |=> !load_en);

    // Power present in the unpowered state starts a test next.
    assert_powerup_starts_test_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_OFF && pwr_good) |=> load_en);

    // Window expiry removes the load.
    assert_window_end_drops_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        win_done |=> !load_en);

    // Interval expiry with power present starts a routine test.
    assert_interval_starts_test_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (period_due && pwr_good) |=> (load_en && !pwrup_test));

endmodule

// File: tb/batt_health_monitor_tb.sv
// Bench: vector table walked once, then directed reset checks.
module batt_health_monitor_tb;
    localparam int WIN = 3;
    localparam int PER = 5;
    localparam int NV  = 41;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic pwr_good = 1'b0;
    logic batt_above_trip = 1'b1;
    logic load_en;
    logic warn_pull_low;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    batt_health_monitor #(.WINDOW_TICKS(WIN), .PERIOD_TICKS(PER)) u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .tick            (tick),
        .pwr_good        (pwr_good),
        .batt_above_trip (batt_above_trip),
        .load_en         (load_en),
        .warn_pull_low   (warn_pull_low)
    );

    // Row: {pwr_good, tick, batt_above_trip, expected load_en, expected warn}
    localparam logic [4:0] VEC [NV] = '{
        5'b00100, // 0  R9 unpowered
        5'b01100, // 1  R9 tick while unpowered
        5'b10110, // 2  R2 power-up test starts
        5'b11010, // 3  R4 low mid-window ignored
        5'b10010, // 4  R4
        5'b11010, // 5  R3 tick 2
        5'b11100, // 6  R3/R4 final tick passes
        5'b11100, // 7  R8 interval t1
        5'b10100, // 8  R8
        5'b11100, // 9  R8 t2
        5'b11100, // 10 R8 t3
        5'b11100, // 11 R8 t4
        5'b11110, // 12 R8 t5 routine test
        5'b11110, // 13 R3
        5'b11110, // 14 R3
        5'b11001, // 15 R5 fail sets warning
        5'b11101, // 16 R8
        5'b11101, // 17 R8
        5'b11101, // 18 R8
        5'b11101, // 19 R8
        5'b11111, // 20 R8 routine test
        5'b11111, // 21 R6
        5'b11111, // 22 R6
        5'b11101, // 23 R6 routine pass keeps warning
        5'b11101, // 24 R6
        5'b00101, // 25 R10 power lost
        5'b01101, // 26 R10
        5'b10111, // 27 R7 power-up test with warning
        5'b11111, // 28 R7
        5'b00101, // 29 R9 abort mid-test
        5'b01001, // 30 R9
        5'b10011, // 31 R7 restart
        5'b11111, // 32 R7
        5'b11111, // 33 R7
        5'b11100, // 34 R7 pass clears
        5'b11100, // 35 R8
        5'b00100, // 36 R9
        5'b10110, // 37 R2
        5'b11110, // 38 R3
        5'b11110, // 39 R3
        5'b11001  // 40 R5 power-up fail sets warning
    };

    function automatic string req_of(input int i);
        if (i <= 1)  return "R9";
        if (i == 2)  return "R2";
        if (i <= 6)  return "R4";
        if (i <= 12) return "R8";
        if (i <= 15) return "R5";
        if (i <= 20) return "R8";
        if (i <= 24) return "R6";
        if (i <= 26) return "R10";
        if (i <= 28) return "R7";
        if (i <= 30) return "R9";
        if (i <= 35) return "R7";
        return "R5";
    endfunction

    task automatic check(input string req, input logic act_l, input logic exp_l,
                         input logic act_w, input logic exp_w);
        n_checks++;
        if (act_l !== exp_l || act_w !== exp_w) begin
            n_fails++;
            $display("FAIL %s: load_en=%b warn=%b expected load_en=%b warn=%b",
                     req, act_l, act_w, exp_l, exp_w);
        end
    endtask

    initial begin
        // R1: reset state, with power present during reset.
        pwr_good = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1", load_en, 1'b0, warn_pull_low, 1'b0);
        pwr_good = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            pwr_good        = VEC[i][4];
            tick            = VEC[i][3];
            batt_above_trip = VEC[i][2];
            @(posedge clk);
            @(negedge clk);
            check(req_of(i), load_en, VEC[i][1], warn_pull_low, VEC[i][0]);
        end

        // R1: reset clears a set warning and a running interval.
        tick = 1'b0;
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R1", load_en, 1'b0, warn_pull_low, 1'b0);
        // R2: releasing reset with power present starts a test next edge.
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R2", load_en, 1'b1, warn_pull_low, 1'b0);
        // R1: reset in mid-test drops the load.
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R1", load_en, 1'b0, warn_pull_low, 1'b0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule